// File: doc/BRIEF.md
# Display Stream M/N Ratio Calculator

This block works out the two ratio pairs that a DisplayPort source programs so that its pixel stream can be carried over a link running on a different clock. The first pair is the data ratio. Its numerator is the pixel clock multiplied by the bytes carried per pixel, and its denominator is the link clock multiplied by the number of active lanes. The second pair is the link ratio, which is simply the pixel clock over the link clock. Each pair has to fit 24-bit register fields. To get there, both members of a pair are halved together, one step per clock, until neither member exceeds 0xFFFFFF. This keeps the ratio approximately intact without a divider or a GCD search.

A caller presents the pixel clock and link clock in kHz, the lane count and the bytes per pixel, then pulses a start strobe. The block forms both products at full width and reduces the two pairs in parallel. When both pairs fit, it presents the four 24-bit values with a one-cycle done strobe. Alongside them it gives the transfer-unit field, which is the transfer-unit size minus one. The results remain on the outputs until a later calculation finishes.

Top module: `mn_ratio_calc`

## Requirements
- R1: After reset, the four ratio outputs and the transfer-unit field are zero and done is low.
- R2: Before reduction, the data-ratio numerator is pixel clock times bytes per pixel and its denominator is link clock times lane count, both formed at 48 bits so that nothing overflows.
- R3: Before reduction, the link-ratio numerator is the pixel clock and its denominator is the link clock.
- R4: While either member of a pair exceeds 0xFFFFFF, both members of that pair shift right by one bit per clock. The result is the unreduced pair shifted right by the smallest count k that brings both members to 0xFFFFFF or less.
- R5: The two pairs reduce independently. Each pair uses its own count k, so a pair that already fits is never shifted.
- R6: With the default transfer-unit size of 64, the transfer-unit field output reads 63 (size minus one, 6 bits) once a result is presented.
- R7: Done is high for exactly one clock. Counting the edge that samples start as edge 1, done rises at edge S+2, where S is the larger of the two pairs' shift counts.
- R8: A start that arrives while a calculation is in progress is ignored. It neither reloads the pairs nor queues a second result.
- R9: All result outputs hold their values from one done until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe; operands are sampled on the edge where it is accepted |
| pix_clk_khz_i | input | CLK_W (28) | Pixel clock in kHz |
| link_clk_khz_i | input | CLK_W (28) | Link clock in kHz |
| lanes_i | input | LANE_W (3) | Active lane count |
| bpp_i | input | BPP_W (3) | Bytes per pixel (3 for 8-bit RGB) |
| data_m_o | output | RATIO_W (24) | Reduced data-ratio numerator |
| data_n_o | output | RATIO_W (24) | Reduced data-ratio denominator |
| link_m_o | output | RATIO_W (24) | Reduced link-ratio numerator |
| link_n_o | output | RATIO_W (24) | Reduced link-ratio denominator |
| tu_field_o | output | TU_W (6) | Transfer-unit size minus one |
| done_o | output | 1 | One-cycle result strobe |

## Verification
The assertions assume only that reset is applied before the first start. They place no restriction on operand values, because a pair that is still too wide must shift on every busy cycle whatever it holds. A zero lane count or zero link clock would give a meaningless ratio, so the stimulus holds the lane count to 1, 2 or 4 and the link clock to nonzero rates. It sweeps pixel clocks from tens of MHz up to the full 28-bit range, so the shift counts run from zero up to several steps. Start is raised and lowered between clock edges, and the busy-time starts are dropped before the running calculation completes.

// File: rtl/mn_pkg.sv
package mn_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    localparam int unsigned PAIR_DATA = 0;
    localparam int unsigned PAIR_LINK = 1;
    localparam int unsigned NUM_PAIRS = 2;

endpackage

// File: rtl/mn_product.sv
module mn_product #(
    parameter int unsigned CLK_W  = 28,
    parameter int unsigned LANE_W = 3,
    parameter int unsigned BPP_W  = 3,
    parameter int unsigned PROD_W = 48
) (
    input  logic [CLK_W-1:0]               pix_clk_i,
    input  logic [CLK_W-1:0]               link_clk_i,
    input  logic [LANE_W-1:0]              lanes_i,
    input  logic [BPP_W-1:0]               bpp_i,
    output logic [mn_pkg::NUM_PAIRS-1:0][PROD_W-1:0] num_o,
    output logic [mn_pkg::NUM_PAIRS-1:0][PROD_W-1:0] den_o
);
    import mn_pkg::*;

    logic [PROD_W-1:0] pix_w, link_w, lanes_w, bpp_w;

    always_comb begin
        pix_w   = PROD_W'(pix_clk_i);
        link_w  = PROD_W'(link_clk_i);
        lanes_w = PROD_W'(lanes_i);
        bpp_w   = PROD_W'(bpp_i);
        num_o[PAIR_DATA] = pix_w * bpp_w;
        den_o[PAIR_DATA] = link_w * lanes_w;
        num_o[PAIR_LINK] = pix_w;
        den_o[PAIR_LINK] = link_w;
    end

endmodule

// File: rtl/mn_pair_reducer.sv
module mn_pair_reducer #(
    parameter int unsigned PROD_W  = 48,
    parameter int unsigned RATIO_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [PROD_W-1:0] num_i,
    input  logic [PROD_W-1:0] den_i,
    output logic [PROD_W-1:0] num_o,
    output logic [PROD_W-1:0] den_o,
    output logic              fit_o
);
    localparam int unsigned HI_W = PROD_W - RATIO_W;

    typedef struct packed {
        logic [PROD_W-1:0] num;
        logic [PROD_W-1:0] den;
    } pair_t;

    pair_t pair_d, pair_q;
    logic  num_fits, den_fits;

    always_comb begin
        num_fits = ~|pair_q.num[PROD_W-1 -: HI_W];
        den_fits = ~|pair_q.den[PROD_W-1 -: HI_W];
        fit_o    = num_fits && den_fits;
        pair_d   = pair_q;
        if (load_i) begin
            pair_d.num = num_i;
            pair_d.den = den_i;
        end else if (!fit_o) begin
            pair_d.num = pair_q.num >> 1;
            pair_d.den = pair_q.den >> 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pair_q <= '0;
        end else begin
            pair_q <= pair_d;
        end
    end

    assign num_o = pair_q.num;
    assign den_o = pair_q.den;

endmodule

// File: rtl/mn_ratio_calc.sv
module mn_ratio_calc #(
    parameter int unsigned CLK_W   = 28,
    parameter int unsigned LANE_W  = 3,
    parameter int unsigned BPP_W   = 3,
    parameter int unsigned RATIO_W = 24,
    parameter int unsigned PROD_W  = 48,
    parameter int unsigned TU_SIZE = 64,
    parameter int unsigned TU_W    = $clog2(TU_SIZE)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [CLK_W-1:0]   pix_clk_khz_i,
    input  logic [CLK_W-1:0]   link_clk_khz_i,
    input  logic [LANE_W-1:0]  lanes_i,
    input  logic [BPP_W-1:0]   bpp_i,
    output logic [RATIO_W-1:0] data_m_o,
    output logic [RATIO_W-1:0] data_n_o,
    output logic [RATIO_W-1:0] link_m_o,
    output logic [RATIO_W-1:0] link_n_o,
    output logic [TU_W-1:0]    tu_field_o,
    output logic               done_o
);
    import mn_pkg::*;

    localparam logic [TU_W-1:0] TU_CODE = TU_W'(TU_SIZE - 1);

    typedef struct packed {
        phase_e             phase;
        logic [RATIO_W-1:0] dm;
        logic [RATIO_W-1:0] dn;
        logic [RATIO_W-1:0] lm;
        logic [RATIO_W-1:0] ln;
        logic [TU_W-1:0]    tu;
        logic               done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NUM_PAIRS-1:0][PROD_W-1:0] prod_num, prod_den;
    logic [NUM_PAIRS-1:0][PROD_W-1:0] red_num, red_den;
    logic [NUM_PAIRS-1:0]             fit_vec;
    logic                             load;
    logic                             busy;

    mn_product #(
        .CLK_W (CLK_W),
        .LANE_W(LANE_W),
        .BPP_W (BPP_W),
        .PROD_W(PROD_W)
    ) prod_i (
        .pix_clk_i (pix_clk_khz_i),
        .link_clk_i(link_clk_khz_i),
        .lanes_i   (lanes_i),
        .bpp_i     (bpp_i),
        .num_o     (prod_num),
        .den_o     (prod_den)
    );

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        mn_pair_reducer #(
            .PROD_W (PROD_W),
            .RATIO_W(RATIO_W)
        ) red_i (
            .clk   (clk),
            .rst_n (rst_n),
            .load_i(load),
            .num_i (prod_num[g]),
            .den_i (prod_den[g]),
            .num_o (red_num[g]),
            .den_o (red_den[g]),
            .fit_o (fit_vec[g])
        );
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        load       = 1'b0;
        busy       = (ctl_q.phase == PH_RUN);
        unique case (ctl_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    load        = 1'b1;
                    ctl_d.phase = PH_RUN;
                end
            end
            PH_RUN: begin
                if (&fit_vec) begin
                    ctl_d.dm    = red_num[PAIR_DATA][RATIO_W-1:0];
                    ctl_d.dn    = red_den[PAIR_DATA][RATIO_W-1:0];
                    ctl_d.lm    = red_num[PAIR_LINK][RATIO_W-1:0];
                    ctl_d.ln    = red_den[PAIR_LINK][RATIO_W-1:0];
                    ctl_d.tu    = TU_CODE;
                    ctl_d.done  = 1'b1;
                    ctl_d.phase = PH_IDLE;
                end
            end
            default: ctl_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign data_m_o   = ctl_q.dm;
    assign data_n_o   = ctl_q.dn;
    assign link_m_o   = ctl_q.lm;
    assign link_n_o   = ctl_q.ln;
    assign tu_field_o = ctl_q.tu;
    assign done_o     = ctl_q.done;

endmodule

// File: rtl/mn_ratio_calc_chk.sv
module mn_ratio_calc_chk #(
    parameter int unsigned PROD_W  = 48,
    parameter int unsigned RATIO_W = 24,
    parameter int unsigned TU_W    = 6
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     start_i,
    input logic                     busy,
    input logic [1:0]               fit_vec,
    input logic [1:0][PROD_W-1:0]   red_num,
    input logic [1:0][PROD_W-1:0]   red_den,
    input logic [RATIO_W-1:0]       data_m_o,
    input logic [RATIO_W-1:0]       data_n_o,
    input logic [RATIO_W-1:0]       link_m_o,
    input logic [RATIO_W-1:0]       link_n_o,
    input logic [TU_W-1:0]          tu_field_o,
    input logic                     done_o
);

    for (genvar g = 0; g < 2; g++) begin : g_pair_chk
        // R4, R5: an oversize pair halves on every busy cycle
        assert_shift_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
            busy && !fit_vec[g] |=> (red_num[g] == ($past(red_num[g]) >> 1))
                                 && (red_den[g] == ($past(red_den[g]) >> 1)));
        // R5: a fitting pair stays put while the other one finishes
        assert_fit_pair_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
            busy && fit_vec[g] |=> $stable(red_num[g]) && $stable(red_den[g]));
    end

    // R7: done is a single-cycle strobe
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: done only follows a cycle where both pairs fit during a run
    assert_done_after_fit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy) && ($past(fit_vec) == 2'b11));

    // R8: start during an unfinished run keeps the run going
    assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start_i && (fit_vec != 2'b11) |=> busy);

    // R9: results only move together with done
    assert_hold_results_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(data_m_o) && $stable(data_n_o) && $stable(link_m_o)
                    && $stable(link_n_o) && $stable(tu_field_o));

endmodule

bind mn_ratio_calc mn_ratio_calc_chk #(
    .PROD_W (PROD_W),
    .RATIO_W(RATIO_W),
    .TU_W   (TU_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .busy      (busy),
    .fit_vec   (fit_vec),
    .red_num   (red_num),
    .red_den   (red_den),
    .data_m_o  (data_m_o),
    .data_n_o  (data_n_o),
    .link_m_o  (link_m_o),
    .link_n_o  (link_n_o),
    .tu_field_o(tu_field_o),
    .done_o    (done_o)
);

// File: tb/mn_ratio_calc_tb.sv
module mn_ratio_calc_tb_top;

    localparam int CLK_W = 28;
    localparam longint LIMIT = 64'hFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [27:0] pix_clk_khz_i = '0;
    logic [27:0] link_clk_khz_i = '0;
    logic [2:0]  lanes_i = '0;
    logic [2:0]  bpp_i = '0;
    logic [23:0] data_m_o, data_n_o, link_m_o, link_n_o;
    logic [5:0]  tu_field_o;
    logic        done_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    mn_ratio_calc dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .pix_clk_khz_i (pix_clk_khz_i),
        .link_clk_khz_i(link_clk_khz_i),
        .lanes_i       (lanes_i),
        .bpp_i         (bpp_i),
        .data_m_o      (data_m_o),
        .data_n_o      (data_n_o),
        .link_m_o      (link_m_o),
        .link_n_o      (link_n_o),
        .tu_field_o    (tu_field_o),
        .done_o        (done_o)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int shifts_for(input longint n, input longint d);
        int k = 0;
        while (((n >> k) > LIMIT) || ((d >> k) > LIMIT)) k++;
        return k;
    endfunction

    // Drives one calculation; returns latency in cycles after the start edge.
    task automatic launch(input longint p, input longint l, input int ln, input int b,
                          input int busy_starts, output int lat);
        @(negedge clk);
        pix_clk_khz_i  = p[27:0];
        link_clk_khz_i = l[27:0];
        lanes_i        = ln[2:0];
        bpp_i          = b[2:0];
        start_i        = 1'b1;
        @(posedge clk);
        @(negedge clk);
        lat = 0;
        if (busy_starts > 0) begin
            pix_clk_khz_i  = 28'd1000;
            link_clk_khz_i = 28'd2000;
            lanes_i        = 3'd1;
            bpp_i          = 3'd1;
        end else begin
            start_i = 1'b0;
        end
        for (int w = 0; w < 60; w++) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
            if (lat >= busy_starts) start_i = 1'b0;
            if (done_o) break;
        end
        start_i = 1'b0;
    endtask

    task automatic run_case(input longint p, input longint l, input int ln, input int b,
                            input int busy_starts);
        longint dn0, dd0, kd, kl, s, edm, edn, elm, eln;
        int lat;
        logic [23:0] hm;
        dn0 = p * b;
        dd0 = l * ln;
        kd  = shifts_for(dn0, dd0);
        kl  = shifts_for(p, l);
        s   = (kd > kl) ? kd : kl;
        edm = dn0 >> kd;
        edn = dd0 >> kd;
        elm = p >> kl;
        eln = l >> kl;
        launch(p, l, ln, b, busy_starts, lat);
        chk(done_o == 1'b1 && lat == s + 1, "R7 latency", longint'(lat), s + 1);
        // R2, R4: data pair
        chk(data_m_o == edm[23:0], "R2/R4 data_m", longint'(data_m_o), edm);
        chk(data_n_o == edn[23:0], "R2/R4 data_n", longint'(data_n_o), edn);
        // R3, R5: link pair with its own shift count
        chk(link_m_o == elm[23:0], "R3/R5 link_m", longint'(link_m_o), elm);
        chk(link_n_o == eln[23:0], "R3/R5 link_n", longint'(link_n_o), eln);
        chk(tu_field_o == 6'd63, "R6 tu_field", longint'(tu_field_o), 63);
        hm = data_m_o;
        @(posedge clk);
        @(negedge clk);
        chk(done_o == 1'b0, "R7 done one cycle", longint'(done_o), 0);
        for (int h = 0; h < 3; h++) begin
            @(posedge clk);
            @(negedge clk);
            if (busy_starts > 0)
                chk(done_o == 1'b0, "R8 no queued result", longint'(done_o), 0);
        end
        chk(data_m_o == hm && link_n_o == eln[23:0], "R9 hold", longint'(data_m_o), longint'(hm));
    endtask

    initial begin : watchdog
        while (!finished) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                failures++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<150000", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin : stim
        longint pclks [6] = '{25175, 148500, 64'hFF_FFFF, 64'h100_0000, 64'h555_5555, 64'hFFF_FFFF};
        longint lclks [3] = '{162000, 270000, 64'h3FF_FFFF};
        int lane_set [3] = '{1, 2, 4};
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(data_m_o == 0 && data_n_o == 0 && link_m_o == 0 && link_n_o == 0,
            "R1 outputs zero", longint'(data_m_o), 0);
        chk(tu_field_o == 0 && done_o == 0, "R1 tu/done zero", longint'(tu_field_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done_o == 0, "R1 done low after release", longint'(done_o), 0);

        foreach (pclks[i])
            foreach (lclks[j])
                foreach (lane_set[k])
                    for (int b = 1; b <= 4; b++)
                        run_case(pclks[i], lclks[j], lane_set[k], b, 0);

        // R8: restarts while a long calculation is running
        run_case(64'hFFF_FFFF, 64'h3FF_FFFF, 4, 4, 3);
        run_case(64'h555_5555, 162000, 2, 3, 2);
        // R5: link pair fits while data pair needs shifting
        run_case(64'hFF_FFFF, 270000, 1, 4, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule